// File: doc/BRIEF.md
# PLL Configuration Register with Lock Emulation

This block holds the 32-bit configuration and status word of one clock multiplier. It interprets software writes the way a real multiplier's control logic would. Setting the power-down bit drops the live lock indication and raises a sticky slip flag. A write that leaves power-down clear reports the loop as locked at once, with no settling delay. Software clears the slip flag by writing a one to it.

Next to the register sits a small state machine. It recomputes the output frequency in Hz from a binary reference frequency and the divider fields held in the word. A write or a change of the reference starts a new computation. The machine loads its operands, runs a bit-serial restoring divider, and then publishes the result with a valid flag. The cold-reset word is a parameter, so one design can serve every multiplier instance on a chip.

State machine: `ST_IDLE` waits for a pending request; `ST_LOAD` latches the operands and decides between the divider and the zero shortcut; `ST_DIV` waits for the divider's done pulse; `ST_DONE` publishes the result. The transitions are IDLE→LOAD (request pending), LOAD→DIV (locked and divisor non-zero), LOAD→DONE (unlocked or zero divisor), DIV→DONE (divider done) and DONE→IDLE (always).

Top module: `pllcfg_unit`

## Requirements
- R1: After reset the word reads as the parameter INIT_CFG with bit 31 set, `locked` is 1, and `rd_data` is 0 until the first read.
- R2: The word keeps its fields at fixed positions: lock at bit 31, slip at bit 30, power-down at bit 12, feedback multiplier at [27:16], post-divider B at [15:13], post-divider A at [10:8] and pre-divider at [5:0]. Every other bit is stored as written and read back unchanged.
- R3: A write with bit 12 set stores the word with bit 31 cleared and bit 30 set, so `locked` is 0 from the next cycle.
- R4: A write with bit 12 clear stores the word with bit 31 set, so `locked` is 1 from the next cycle.
- R5: A write with bit 12 clear and bit 30 set clears the slip flag.
- R6: A write with bit 12 clear and bit 30 clear leaves the slip flag at its previous value.
- R7: When `freq_valid` is 1 and the word is locked, `freq_hz` equals floor(ref_hz × multiplier / (pre-divider × A × B)).
- R8: When `freq_valid` is 1 and the word is unlocked, `freq_hz` is 0.
- R9: When the product pre-divider × A × B is zero, `freq_hz` is 0 once valid.
- R10: Each write and each change of `ref_hz` lowers `freq_valid` from the next cycle until a new result is ready. With no such event, `freq_valid` stays high and `freq_hz` stays stable.
- R11: `rd_data` takes the stored word one cycle after `rd_en` and holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to write |
| rd_en | input | 1 | Read strobe |
| ref_hz | input | REF_W | Reference frequency in Hz |
| rd_data | output | 32 | Readback word, registered |
| locked | output | 1 | Live lock indication (bit 31) |
| freq_hz | output | REF_W+12 | Computed output frequency in Hz |
| freq_valid | output | 1 | `freq_hz` is current |

## Verification
The bench targets the slip flag in normal mode. A design that treated a written zero as a clear would lose a loss-of-lock event, and a design that stored the written bit would make the flag impossible to clear by writing one. It drives zero pre- and post-dividers: a naive divider would return all ones or hang there instead of reporting zero. It also checks power-down words that carry non-zero dividers, where a design that ignored the lock bit would still report a frequency. Reference changes with no write are checked as well; a design that recomputed only on writes would leave `freq_valid` high with a stale frequency.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;
    localparam int CFG_W    = 32;
    localparam int LOCK_BIT = 31;
    localparam int SLIP_BIT = 30;
    localparam int PDN_BIT  = 12;
    localparam int FB_LSB   = 16;
    localparam int FB_W     = 12;
    localparam int ODB_LSB  = 13;
    localparam int ODB_W    = 3;
    localparam int ODA_LSB  = 8;
    localparam int ODA_W    = 3;
    localparam int PRE_LSB  = 0;
    localparam int PRE_W    = 6;
    localparam int DEN_W    = PRE_W + ODA_W + ODB_W;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DIV,
        ST_DONE
    } freq_state_t;

    typedef struct packed {
        logic [FB_W-1:0]  mult;
        logic [PRE_W-1:0] pre;
        logic [ODA_W-1:0] oda;
        logic [ODB_W-1:0] odb;
    } pll_fields_t;
endpackage

// File: rtl/pllcfg_csr.sv
module pllcfg_csr
    import pllcfg_pkg::*;
#(
    parameter logic [CFG_W-1:0] INIT_CFG = 32'h00222101
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [CFG_W-1:0] rd_data,
    output logic             cfg_lock,
    output pll_fields_t      cfg_fld
);
    localparam logic [CFG_W-1:0] RESET_WORD = INIT_CFG | (CFG_W'(1) << LOCK_BIT);

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_nxt;

    // Write interpretation: power-down drops lock and records a slip;
    // normal mode forces lock and clears slip only on a written one.
    always_comb begin
        cfg_nxt = wr_data;
        if (wr_data[PDN_BIT]) begin
            cfg_nxt[LOCK_BIT] = 1'b0;
            cfg_nxt[SLIP_BIT] = 1'b1;
        end else begin
            cfg_nxt[LOCK_BIT] = 1'b1;
            cfg_nxt[SLIP_BIT] = wr_data[SLIP_BIT] ? 1'b0 : cfg_q[SLIP_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= RESET_WORD;
            rd_data <= '0;
        end else begin
            if (wr_en) cfg_q <= cfg_nxt;
            if (rd_en) rd_data <= cfg_q;
        end
    end

    assign cfg_lock     = cfg_q[LOCK_BIT];
    assign cfg_fld.mult = cfg_q[FB_LSB +: FB_W];
    assign cfg_fld.pre  = cfg_q[PRE_LSB +: PRE_W];
    assign cfg_fld.oda  = cfg_q[ODA_LSB +: ODA_W];
    assign cfg_fld.odb  = cfg_q[ODB_LSB +: ODB_W];
endmodule

// File: rtl/pllcfg_divcore.sv
module pllcfg_divcore #(
    parameter int NUM_W = 44,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(NUM_W);

    logic [NUM_W-1:0] shreg;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W:0]   rem_nxt;

    // One restoring step per cycle: quotient bits shift in as dividend bits shift out.
    always_comb begin
        trial   = {rem, shreg[NUM_W-1]};
        fits    = trial >= {1'b0, den_q};
        rem_nxt = fits ? (trial - {1'b0, den_q}) : trial;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            rem   <= '0;
            den_q <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else if (load) begin
            shreg <= num;
            rem   <= '0;
            den_q <= den;
            cnt   <= CNT_INIT;
            done  <= 1'b0;
        end else if (cnt != '0) begin
            shreg <= {shreg[NUM_W-2:0], fits};
            rem   <= rem_nxt[DEN_W-1:0];
            cnt   <= cnt - 1'b1;
            done  <= (cnt == CNT_W'(1));
        end else begin
            done  <= 1'b0;
        end
    end

    assign quot = shreg;
endmodule

// File: rtl/pllcfg_freq_ctl.sv
module pllcfg_freq_ctl
    import pllcfg_pkg::*;
#(
    parameter int REF_W = 32,
    parameter int NUM_W = REF_W + FB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic [REF_W-1:0] ref_hz,
    input  logic             lock,
    input  pll_fields_t      fld,
    input  logic             div_done,
    input  logic [NUM_W-1:0] div_quot,
    output logic             div_load,
    output logic [NUM_W-1:0] div_num,
    output logic [DEN_W-1:0] div_den,
    output logic [NUM_W-1:0] freq_hz,
    output logic             freq_valid
);
    freq_state_t      st_q;
    freq_state_t      st_nxt;
    logic [REF_W-1:0] ref_q;
    logic             pend_q;
    logic             zero_q;
    logic             skip;

    assign div_den = DEN_W'(fld.pre) * DEN_W'(fld.oda) * DEN_W'(fld.odb);
    assign div_num = NUM_W'(ref_q) * NUM_W'(fld.mult);
    assign skip    = !lock || (div_den == '0);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // Next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: if (pend_q) st_nxt = ST_LOAD;
            ST_LOAD: st_nxt = skip ? ST_DONE : ST_DIV;
            ST_DIV:  if (div_done) st_nxt = ST_DONE;
            ST_DONE: st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q   <= '0;
            pend_q  <= 1'b1;
            zero_q  <= 1'b0;
            freq_hz <= '0;
        end else begin
            ref_q <= ref_hz;
            if (trigger || (ref_hz != ref_q)) pend_q <= 1'b1;
            else if (st_q == ST_IDLE)         pend_q <= 1'b0;
            if (st_q == ST_LOAD) zero_q <= skip;
            if (st_q == ST_DONE) freq_hz <= zero_q ? '0 : div_quot;
        end
    end

    assign div_load   = (st_q == ST_LOAD) && !skip;
    assign freq_valid = (st_q == ST_IDLE) && !pend_q;
endmodule

// File: rtl/pllcfg_unit.sv
module pllcfg_unit
    import pllcfg_pkg::*;
#(
    parameter logic [31:0] INIT_CFG = 32'h00222101,
    parameter int          REF_W    = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [31:0]           wr_data,
    input  logic                  rd_en,
    input  logic [REF_W-1:0]      ref_hz,
    output logic [31:0]           rd_data,
    output logic                  locked,
    output logic [REF_W+FB_W-1:0] freq_hz,
    output logic                  freq_valid
);
    localparam int NUM_W = REF_W + FB_W;

    pll_fields_t      fld;
    logic             lock_w;
    logic             div_load;
    logic             div_done;
    logic [NUM_W-1:0] div_num;
    logic [DEN_W-1:0] div_den;
    logic [NUM_W-1:0] div_quot;

    pllcfg_csr #(.INIT_CFG(INIT_CFG)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cfg_lock(lock_w), .cfg_fld(fld)
    );

    pllcfg_freq_ctl #(.REF_W(REF_W), .NUM_W(NUM_W)) u_ctl (
        .clk(clk), .rst_n(rst_n), .trigger(wr_en), .ref_hz(ref_hz),
        .lock(lock_w), .fld(fld), .div_done(div_done), .div_quot(div_quot),
        .div_load(div_load), .div_num(div_num), .div_den(div_den),
        .freq_hz(freq_hz), .freq_valid(freq_valid)
    );

    pllcfg_divcore #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load), .num(div_num),
        .den(div_den), .done(div_done), .quot(div_quot)
    );

    assign locked = lock_w;
endmodule

// File: rtl/pllcfg_chk.sv
module pllcfg_chk #(
    parameter int REF_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [31:0]         wr_data,
    input logic                rd_en,
    input logic [31:0]         rd_data,
    input logic                locked,
    input logic [REF_W+11:0]   freq_hz,
    input logic                freq_valid
);
    // R3
    pdn_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_data[12] |=> !locked);
    // R3
    pdn_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && $past(wr_en && wr_data[12]) |=> rd_data[30] && !rd_data[31]);
    // R4
    run_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_data[12] |=> locked);
    // R5
    slip_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && $past(wr_en && !wr_data[12] && wr_data[30]) |=> !rd_data[30]);
    // R8
    unlocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid && !locked |-> freq_hz == '0);
    // R10
    wr_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !freq_valid);
    // R10
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_valid && $past(freq_valid) |-> $stable(freq_hz));
    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

bind pllcfg_unit pllcfg_chk #(.REF_W(REF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .locked(locked),
    .freq_hz(freq_hz), .freq_valid(freq_valid)
);

// File: tb/sim_pllcfg_unit.sv
module sim_pllcfg_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] ref_hz = 32'd25_000_000;
    logic [31:0] rd_data;
    logic        locked;
    logic [43:0] freq_hz;
    logic        freq_valid;

    int errs = 0;
    int checks = 0;
    logic [31:0] exp_cfg;
    logic [31:0] last_rd;

    always #5 clk = ~clk;

    pllcfg_unit #(.INIT_CFG(32'h00222101), .REF_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .ref_hz(ref_hz), .rd_data(rd_data), .locked(locked),
        .freq_hz(freq_hz), .freq_valid(freq_valid)
    );

    function automatic logic [31:0] model_write(logic [31:0] old, logic [31:0] wd);
        logic [31:0] n;
        n = wd;
        if (wd[12]) begin
            n[31] = 1'b0; n[30] = 1'b1;
        end else begin
            n[31] = 1'b1; n[30] = wd[30] ? 1'b0 : old[30];
        end
        return n;
    endfunction

    function automatic logic [63:0] model_freq(logic [31:0] c, logic [31:0] r);
        logic [63:0] d;
        d = 64'(c[5:0]) * 64'(c[10:8]) * 64'(c[15:13]);
        if (!c[31] || d == 64'd0) return 64'd0;
        return (64'(r) * 64'(c[27:16])) / d;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [31:0] wd);
        @(negedge clk); wr_en = 1'b1; wr_data = wd;
        @(negedge clk); wr_en = 1'b0;
        exp_cfg = model_write(exp_cfg, wd);
        chk(freq_valid == 1'b0, "R10 valid drop after write", 64'(freq_valid), 64'd0);
    endtask

    task automatic do_read();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        last_rd = rd_data;
    endtask

    task automatic wait_valid();
        int n = 0;
        while (!freq_valid && n < 300) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic check_all(input string ftag);
        do_read();
        chk(last_rd == exp_cfg, "R2 readback", 64'(last_rd), 64'(exp_cfg));
        chk(locked == exp_cfg[31], exp_cfg[31] ? "R4 locked" : "R3 locked", 64'(locked), 64'(exp_cfg[31]));
        wait_valid();
        chk(freq_valid && 64'(freq_hz) == model_freq(exp_cfg, ref_hz), ftag,
            64'(freq_hz), model_freq(exp_cfg, ref_hz));
    endtask

    function automatic string freq_tag(logic [31:0] c);
        if (!c[31]) return "R8 unlocked freq";
        if (c[5:0] == 0 || c[10:8] == 0 || c[15:13] == 0) return "R9 zero divisor";
        return "R7 freq";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int unsigned seed_junk;
        logic [31:0] wd;
        logic [31:0] held;
        seed_junk = $urandom(32'd48611);
        exp_cfg = 32'h80222101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(locked == 1'b1, "R1 locked after reset", 64'(locked), 64'd1);
        chk(rd_data == 32'd0, "R1 rd_data before read", 64'(rd_data), 64'd0);
        check_all("R7 freq at reset 850MHz");
        chk(freq_hz == 44'd850_000_000, "R1 default freq", 64'(freq_hz), 64'd850_000_000);

        // R10 stable while idle
        held = 32'(freq_hz);
        repeat (5) @(negedge clk);
        chk(freq_valid && 32'(freq_hz) == held, "R10 hold idle", 64'(freq_hz), 64'(held));

        // R3 power-down with live dividers
        do_write(32'h00221101);
        check_all("R8 powered-down freq zero");
        chk(last_rd[30] == 1'b1, "R3 slip set", 64'(last_rd[30]), 64'd1);

        // R6 normal write, slip bit written 0 keeps it
        do_write(32'h01228606);
        check_all("R7 freq 50347222");
        chk(last_rd[30] == 1'b1, "R6 slip kept", 64'(last_rd[30]), 64'd1);
        chk(freq_hz == 44'd50_347_222, "R7 exact value", 64'(freq_hz), 64'd50_347_222);

        // R11 rd_data holds without a read
        held = last_rd;
        do_write(32'h40c02105);
        repeat (2) @(negedge clk);
        chk(rd_data == held, "R11 rd hold", 64'(rd_data), 64'(held));
        // R5 slip cleared by written one
        check_all("R7 freq 960MHz");
        chk(last_rd[30] == 1'b0, "R5 slip cleared", 64'(last_rd[30]), 64'd0);

        // R6 slip stays clear when written 0
        do_write(32'h00202101);
        check_all("R7 freq 800MHz");
        chk(last_rd[30] == 1'b0, "R6 slip stays clear", 64'(last_rd[30]), 64'd0);

        // R9 zero pre-divider and zero post-divider
        do_write(32'h00222100);
        check_all("R9 zero pre-divider");
        do_write(32'h00220101);
        check_all("R9 zero post-divider");

        // R10 reference change without a write
        do_write(32'h00202101);
        check_all("R7 freq before ref change");
        @(negedge clk); ref_hz = 32'd33_333_333;
        @(negedge clk);
        chk(freq_valid == 1'b0, "R10 valid drop on ref change", 64'(freq_valid), 64'd0);
        check_all("R10 freq after ref change");

        // Random mix
        for (int i = 0; i < 60; i++) begin
            wd = $urandom;
            wd[12] = ($urandom % 4 == 0);
            if ($urandom % 6 == 0) wd[5:0] = 6'd0;
            if ($urandom % 5 == 0) begin
                @(negedge clk); ref_hz = $urandom % 200_000_000;
            end
            do_write(wd);
            check_all(freq_tag(exp_cfg));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule